// File: doc/BRIEF.md
# MII Nibble Frame Transmitter

This block turns a byte stream into a complete Ethernet frame on a 4-bit MII transmit port. It sends one nibble per transmit clock. The upstream source supplies the frame body over a valid/ready handshake and marks the final byte with a last flag. The body holds the destination address, the source address, the type/length field and the payload. The first valid byte seen while the block is idle starts a new frame.

The block puts the framing around that body. It sends seven 0x55 bytes and a 0xD5 delimiter, then the body. It appends zero bytes when the body is shorter than the minimum, and then the 32-bit frame check sequence. After each frame it keeps the enable low for the inter-frame gap. A body longer than the maximum is cut at the limit and sent with a valid check sequence. A one-cycle error pulse is raised, and the rest of the oversized body is taken in and discarded. If the source fails to hold valid when a data byte is due, the payload is closed at that point, padded if short, and flagged the same way.

Top module: `mii_frame_tx`

## Requirements
- R1: After reset, tx_en is 0, txd is 0 and in_ready is 0.
- R2: Each frame opens with 15 nibbles of value 5 followed by one nibble of value 0xD on txd.
- R3: Every body byte is sent as two nibbles, low nibble first, in the order the bytes were accepted, starting right after the 0xD nibble.
- R4: A body of fewer than 60 bytes is extended with 0x00 bytes to exactly 60 bytes before the check sequence.
- R5: The 4 check bytes follow the (padded) body. They are the complement of a CRC-32 computed over the whole padded body, using reflected polynomial 0xEDB88320 with the register preset to 0xFFFFFFFF. They are sent least significant byte first, each byte low nibble first.
- R6: tx_en stays high without a break from the first preamble nibble to the last check nibble, and it falls only after that nibble.
- R7: Between the last nibble of one frame and the first of the next, tx_en is low for at least 24 clocks.
- R8: At most 1514 body bytes are sent. When more are offered, frame_err pulses for one clock, the frame ends with a correct check sequence over the first 1514 bytes, and the remaining input bytes up to and including the one with in_last are accepted and dropped. The next frame is unaffected.
- R9: in_ready is high only when a body byte is taken into the frame, which happens on the last delimiter nibble or on the high nibble of a body byte. The one exception is while the block drains an oversized body. In particular, in_ready is never high during padding, the check sequence or the gap of a normal frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, one nibble per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Body byte present |
| in_data | input | 8 | Body byte |
| in_last | input | 1 | Marks the final body byte |
| in_ready | output | 1 | Byte accepted on this edge when in_valid is high |
| txd | output | 4 | MII transmit nibble |
| tx_en | output | 1 | MII transmit enable |
| frame_err | output | 1 | One-clock pulse on truncation or underflow |

## Verification
The hardest case to reach is the oversized body. The source must keep feeding bytes past the 1514-byte limit, while the block has already moved on to the check sequence and then drains the leftover bytes during the gap. The next frame must then start clean. The stimulus sends a 1520-byte and a 1600-byte body, each followed at once by a normal frame whose source raises valid during the gap. Exact-limit bodies (59, 60, 61 and 1514 bytes) are mixed with random short bodies. Every captured nibble is checked against a model that builds the frame independently.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_DATA,
        ST_PAD,
        ST_FCS,
        ST_GAP
    } tx_state_e;

    localparam logic [7:0]  PRE_BYTE  = 8'h55;
    localparam logic [7:0]  SFD_BYTE  = 8'hD5;
    localparam logic [31:0] CRC_POLY  = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED  = 32'hFFFFFFFF;
endpackage

// File: rtl/mii_tx_crc_step.sv
module mii_tx_crc_step #(
    parameter int DW = 8
) (
    input  logic [31:0]   crc_in,
    input  logic [DW-1:0] data,
    output logic [31:0]   crc_out
);
    import mii_tx_pkg::*;

    logic [31:0] chain [0:DW];
    assign chain[0] = crc_in;

    // one reflected shift stage per input bit, LSB first
    for (genvar i = 0; i < DW; i++) begin : g_bit
        logic fb;
        assign fb = chain[i][0] ^ data[i];
        assign chain[i+1] = (chain[i] >> 1) ^ (fb ? CRC_POLY : 32'h0);
    end

    assign crc_out = chain[DW];
endmodule

// File: rtl/mii_tx_nib_sel.sv
module mii_tx_nib_sel #(
    parameter int NW = 4
) (
    input  logic [2*NW-1:0] word_in,
    input  logic            upper,
    output logic [NW-1:0]   nib
);
    assign nib = upper ? word_in[2*NW-1:NW] : word_in[NW-1:0];
endmodule

// File: rtl/mii_frame_tx.sv
module mii_frame_tx #(
    parameter int PRE_LEN  = 7,
    parameter int MIN_BODY = 60,
    parameter int MAX_BODY = 1514,
    parameter int GAP_NIB  = 24,
    parameter int FCS_LEN  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       in_ready,
    output logic [3:0] txd,
    output logic       tx_en,
    output logic       frame_err
);
    import mii_tx_pkg::*;

    localparam int LEN_W   = $clog2(MAX_BODY + 2);
    localparam int CNT_MAX = (GAP_NIB > PRE_LEN + FCS_LEN) ? GAP_NIB : PRE_LEN + FCS_LEN;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int NIB_MAX = 2 * (PRE_LEN + 1 + MAX_BODY + FCS_LEN);
    localparam int NIB_W   = $clog2(NIB_MAX + 2);

    typedef struct packed {
        tx_state_e        state;
        logic             phase;
        logic [CNT_W-1:0] cnt;
        logic [LEN_W-1:0] len;
        logic [7:0]       cur;
        logic [31:0]      crc;
        logic             last;
        logic             drop;
        logic             err;
    } regs_t;

    regs_t r_d, r_q;

    logic        want_data;
    logic        drain;
    logic [7:0]  step_byte;
    logic [31:0] crc_nx;
    logic [31:0] fcs_shift;

    assign step_byte = (want_data && in_valid) ? in_data : 8'h00;

    mii_tx_crc_step #(.DW(8)) u_crc (
        .crc_in (r_q.crc),
        .data   (step_byte),
        .crc_out(crc_nx)
    );

    mii_tx_nib_sel #(.NW(4)) u_nib (
        .word_in(r_q.cur),
        .upper  (r_q.phase),
        .nib    (txd)
    );

    always_comb begin
        want_data = r_q.phase &&
                    ((r_q.state == ST_PRE && r_q.cnt == CNT_W'(PRE_LEN)) ||
                     (r_q.state == ST_DATA && !r_q.last && r_q.len < LEN_W'(MAX_BODY)));
        drain     = r_q.drop && (r_q.state == ST_GAP || r_q.state == ST_IDLE);
        in_ready  = want_data || drain;
        fcs_shift = ~r_q.crc >> (8 * (int'(r_q.cnt) + 1));

        r_d     = r_q;
        r_d.err = 1'b0;
        if (drain && in_valid && in_last) r_d.drop = 1'b0;

        case (r_q.state)
            ST_IDLE: begin
                if (!r_q.drop && in_valid) begin
                    r_d.state = ST_PRE;
                    r_d.phase = 1'b0;
                    r_d.cnt   = '0;
                    r_d.len   = '0;
                    r_d.last  = 1'b0;
                    r_d.cur   = PRE_BYTE;
                    r_d.crc   = CRC_SEED;
                end
            end
            ST_PRE, ST_DATA, ST_PAD: begin
                r_d.phase = ~r_q.phase;
                if (r_q.phase) begin
                    if (r_q.state == ST_PRE && r_q.cnt != CNT_W'(PRE_LEN)) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                        r_d.cur = (r_q.cnt == CNT_W'(PRE_LEN - 1)) ? SFD_BYTE : PRE_BYTE;
                    end else if (want_data && in_valid) begin
                        r_d.state = ST_DATA;
                        r_d.cur   = in_data;
                        r_d.crc   = crc_nx;
                        r_d.len   = r_q.len + 1'b1;
                        r_d.last  = in_last;
                    end else begin
                        if (r_q.state != ST_PAD && !r_q.last) begin
                            r_d.err  = 1'b1;
                            r_d.drop = !want_data;
                        end
                        if (r_q.len < LEN_W'(MIN_BODY)) begin
                            r_d.state = ST_PAD;
                            r_d.cur   = 8'h00;
                            r_d.crc   = crc_nx;
                            r_d.len   = r_q.len + 1'b1;
                        end else begin
                            r_d.state = ST_FCS;
                            r_d.cnt   = '0;
                            r_d.cur   = ~r_q.crc[7:0];
                        end
                    end
                end
            end
            ST_FCS: begin
                r_d.phase = ~r_q.phase;
                if (r_q.phase) begin
                    if (r_q.cnt == CNT_W'(FCS_LEN - 1)) begin
                        r_d.state = ST_GAP;
                        r_d.cnt   = '0;
                        r_d.cur   = 8'h00;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                        r_d.cur = fcs_shift[7:0];
                    end
                end
            end
            ST_GAP: begin
                r_d.phase = 1'b0;
                r_d.cnt   = r_q.cnt + 1'b1;
                if (r_q.cnt == CNT_W'(GAP_NIB - 1)) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_en     = (r_q.state == ST_PRE) || (r_q.state == ST_DATA) ||
                       (r_q.state == ST_PAD) || (r_q.state == ST_FCS);
    assign frame_err = r_q.err;

    // ---------------- checking logic and assertions ----------------
    logic [CNT_W-1:0] low_q;
    logic             sent_q;
    logic [NIB_W-1:0] nib_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q  <= '0;
            sent_q <= 1'b0;
            nib_q  <= '0;
        end else begin
            if (tx_en) begin
                low_q  <= '0;
                nib_q  <= nib_q + 1'b1;
                sent_q <= 1'b1;
            end else begin
                nib_q <= '0;
                if (low_q != CNT_W'(GAP_NIB)) low_q <= low_q + 1'b1;
            end
        end
    end

    assert_pre_nibble_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_PRE && !(r_q.cnt == CNT_W'(PRE_LEN) && r_q.phase)) |-> txd == 4'h5);

    assert_en_ends_in_fcs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_en) |-> $past(r_q.state) == ST_FCS);

    assert_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_en) && sent_q) |-> low_q == CNT_W'(GAP_NIB));

    assert_frame_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> nib_q < NIB_W'(NIB_MAX));

    assert_err_into_fcs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> (r_q.state == ST_FCS || r_q.state == ST_PAD));

    assert_ready_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !r_q.drop) |-> tx_en);
endmodule

// File: tb/mii_frame_tx_test.sv
`timescale 1ns/1ps
module mii_frame_tx_test;
    localparam int MAXB = 1514;
    localparam int MINB = 60;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic [3:0] txd;
    logic       tx_en;
    logic       frame_err;

    mii_frame_tx uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .txd(txd), .tx_en(tx_en),
        .frame_err(frame_err)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [7:0] body [0:2047];
    logic [3:0] cap  [0:4095];
    logic [3:0] expn [0:4095];
    int cap_n = 0;
    int exp_n = 0;
    int frames_done = 0;
    int hs_en = 0, hs_all = 0, errs = 0;
    int low_run = 0;
    bit in_frame = 0, seen_frame = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++;
                fails++;
                $display("FAIL watchdog expired actual=%0d expected=0", cycles);
                summary();
                $finish;
            end
        end
    end

    // monitor, sampled late in the low half of the clock
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n) begin
                if (tx_en) begin
                    if (!in_frame) begin
                        if (seen_frame)
                            chk(low_run >= 24, "R7 gap length", low_run, 24);
                        cap_n = 0;
                        in_frame = 1;
                    end
                    cap[cap_n] = txd;
                    cap_n++;
                    if (in_valid && in_ready) hs_en++;
                    low_run = 0;
                end else begin
                    if (in_frame) begin
                        in_frame = 0;
                        seen_frame = 1;
                        frames_done++;
                    end
                    low_run++;
                end
                if (in_valid && in_ready) hs_all++;
                if (frame_err) errs++;
            end
        end
    end

    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] x = c;
        for (int i = 0; i < 8; i++)
            x = (x >> 1) ^ (((x[0] ^ b[i]) != 1'b0) ? 32'hEDB88320 : 32'h0);
        return x;
    endfunction

    task automatic put_byte(input logic [7:0] b);
        expn[exp_n]   = b[3:0];
        expn[exp_n+1] = b[7:4];
        exp_n += 2;
    endtask

    task automatic build_expected(input int len);
        int bn;
        int nb;
        logic [31:0] c;
        logic [7:0] v;
        bn = (len > MAXB) ? MAXB : len;
        nb = (bn < MINB) ? MINB : bn;
        exp_n = 0;
        c = 32'hFFFFFFFF;
        for (int i = 0; i < 7; i++) put_byte(8'h55);
        put_byte(8'hD5);
        for (int i = 0; i < nb; i++) begin
            v = (i < bn) ? body[i] : 8'h00;
            c = crc_byte(c, v);
            put_byte(v);
        end
        c = ~c;
        for (int i = 0; i < 4; i++) put_byte(c[8*i +: 8]);
    endtask

    task automatic cmp_range(input int lo, input int hi, input string tag);
        int bad = -1;
        for (int i = lo; i < hi; i++)
            if (bad < 0 && cap[i] !== expn[i]) bad = i;
        if (bad < 0) chk(1'b1, tag, 0, 0);
        else chk(1'b0, tag, int'(cap[bad]), int'(expn[bad]));
    endtask

    task automatic drive(input int len);
        int idx = 0;
        while (idx < len) begin
            @(negedge clk);
            #1;
            in_valid = 1'b1;
            in_data  = body[idx];
            in_last  = (idx == len - 1);
            if (in_ready) idx++;
        end
        @(negedge clk);
        #1;
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic run_frame(input int len);
        int target;
        int bn;
        int nb;
        target = frames_done + 1;
        hs_en = 0;
        hs_all = 0;
        errs = 0;
        bn = (len > MAXB) ? MAXB : len;
        nb = (bn < MINB) ? MINB : bn;
        build_expected(len);
        fork
            drive(len);
            wait (frames_done == target);
        join
        chk(cap_n == exp_n, "R6 nibble count with tx_en high", cap_n, exp_n);
        cmp_range(0, 16, "R2 preamble and delimiter");
        cmp_range(16, 16 + 2*bn, "R3 body nibbles");
        cmp_range(16 + 2*bn, 16 + 2*nb, "R4 zero padding");
        cmp_range(16 + 2*nb, 24 + 2*nb, "R5 check sequence");
        chk(errs == ((len > MAXB) ? 1 : 0), "R8 frame_err pulses", errs, (len > MAXB) ? 1 : 0);
        chk(hs_en == bn, "R9 bytes taken while sending", hs_en, bn);
        chk(hs_all == len, "R8 bytes accepted incl. drained", hs_all, len);
    endtask

    task automatic fill_random(input int len);
        for (int i = 0; i < len; i++) body[i] = 8'($urandom);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(tx_en == 1'b0, "R1 tx_en after reset", int'(tx_en), 0);
        chk(txd == 4'h0, "R1 txd after reset", int'(txd), 0);
        chk(in_ready == 1'b0, "R1 in_ready after reset", int'(in_ready), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(tx_en == 1'b0 && in_ready == 1'b0, "R1 idle without input", int'(tx_en), 0);

        // directed: header-like pattern, sizes around the pad limit (R4)
        for (int i = 0; i < 60; i++) body[i] = 8'(i * 7 + 3);
        run_frame(1);
        run_frame(14);
        run_frame(59);
        run_frame(60);
        run_frame(61);
        for (int i = 0; i < 64; i++) body[i] = 8'hFF;
        run_frame(64);

        // random short bodies
        for (int k = 0; k < 14; k++) begin
            int len = 1 + int'($urandom % 160);
            fill_random(len);
            run_frame(len);
        end

        // R8: exactly at limit, over the limit, then a normal frame right after
        fill_random(1514);
        run_frame(1514);
        fill_random(1520);
        run_frame(1520);
        fill_random(70);
        run_frame(70);
        fill_random(1600);
        run_frame(1600);
        fill_random(45);
        run_frame(45);

        repeat (30) @(negedge clk);
        summary();
        $finish;
    end
endmodule